// File: doc/BRIEF.md
# Motion Lamp Mode and Override Sequencer

This block decides in which operating mode a motion-activated lamp controller runs. A three-state selector input, already decoded, chooses between a lamp that is forced off, a lamp that is forced on, and automatic operation. In automatic operation the block runs its own small state machine. Power-on warm-up blocks motion triggers. A quick-install mode gives short lamp pulses for aiming the sensor. A manual override holds the lamp on until a long timeout expires.

The user sends commands with the wall switch. The block watches the zero-crossing square wave from the mains. Each time the edges stop for a short time and then come back, it counts one off/on event. Two such events close together form an override gesture. A gesture made soon after power-on enters quick-install mode. A gesture made later toggles between automatic operation and override-on. If the mains stays away for several seconds, initialization starts again. All timing runs on a 16 kHz tick enable. The long timeouts use a derived one-second pulse. While the selector is open, the block also drives a square wave at the tick rate divided by 512.

Top module: `lamp_mode_sequencer`

## Requirements
- R1: `mode_sel` = 00 gives `mode_o` = 0 (OFF) and `mode_sel` = 01 gives `mode_o` = 1 (ON), one clock after the selector changes, whatever the internal state. Codes 10 and 11 both select automatic operation.
- R2: While `mode_sel[1]` is 1, `sq_out` toggles every SQ_DIV/2 ticks and changes on no other cycle. While `mode_sel[1]` is 0, `sq_out` is held at 0.
- R3: Directly after reset, `warm_inh` is 1 and automatic operation reports `mode_o` = 4 (WARM). After WARMUP_SEC seconds of ticks, `warm_inh` drops to 0 and `mode_o` becomes 2 (AUTO).
- R4: A gap in `zc_in` edges shorter than ZC_LOSS_TICKS ticks is not a loss of mains and counts as no off/on event.
- R5: Two off/on events form a gesture only if they fall inside a window of GESTURE_SEC seconds. Two single events farther apart change nothing.
- R6: A gesture in AUTO while fewer than QUICK_WIN_SEC seconds have passed since initialization gives `mode_o` = 3 (QUICK) with `warm_inh` = 0.
- R7: In QUICK, each `trig` pulse restarts an idle timer. After QUICK_IDLE_SEC seconds without a trigger the block returns to automatic operation. If warm-up has not finished by then, it reports WARM with `warm_inh` = 1.
- R8: Once the quick-install window has passed, a gesture in AUTO gives `mode_o` = 1 (ON), and a gesture in override-on gives AUTO again.
- R9: Override-on ends by itself after OVR_ON_SEC seconds and reports AUTO.
- R10: If the mains is absent for more than ZC_GAP_SEC seconds, initialization restarts. Override state is cleared, and warm-up runs again for its full length.
- R11: A gesture made while the selector is 00 or 01 has no effect. A gesture made while in QUICK has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 16 kHz timing enable, one clock wide |
| mode_sel | input | 2 | Decoded selector: 00 forced off, 01 forced on, 1x automatic |
| zc_in | input | 1 | Zero-crossing square wave, synchronised to clk |
| trig | input | 1 | Qualified motion trigger strobe |
| mode_o | output | 3 | Effective mode: 0 OFF, 1 ON, 2 AUTO, 3 QUICK, 4 WARM |
| warm_inh | output | 1 | High while motion triggers must be ignored for warm-up |
| sq_out | output | 1 | Square wave at tick/SQ_DIV while automatic operation is selected |

## Verification
The checker tests on every cycle that the selector codes for forced off and forced on lead to OFF and ON, that the square wave stays low outside automatic selection and moves only on a tick, that the mode code is legal, and that WARM always comes with the inhibit while QUICK never does. The gesture window, the quick-install entry and its idle timeout, the override toggle and its expiry, short mains dips, and restart after a long outage all depend on long stretches of mains and trigger activity. Only the bench scenarios show these, by comparing the effective mode and the inhibit against expected values queued at known times.

// File: rtl/lms_pkg.sv
// Shared types for the lamp mode sequencer.
// Assumes: the effective-mode encoding is decoded by downstream blocks and must stay fixed.
package lms_pkg;

    typedef enum logic [2:0] {
        EM_OFF   = 3'd0,
        EM_ON    = 3'd1,
        EM_AUTO  = 3'd2,
        EM_QUICK = 3'd3,
        EM_WARM  = 3'd4
    } eff_mode_e;

    typedef enum logic [1:0] {
        ST_AUTO   = 2'd0,
        ST_OVR_ON = 2'd1,
        ST_QUICK  = 2'd2
    } auto_st_e;

endpackage

// File: rtl/lms_prescale.sv
// Tick prescaler: produces a one-second strobe and the automatic-mode square wave.
// Assumes: tick is a single-cycle enable; init realigns the second boundary.
module lms_prescale #(
    parameter int TICKS_PER_SEC = 16000,
    parameter int SQ_DIV        = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic init,
    input  logic sq_en,
    output logic sec_pulse,
    output logic sq_out
);
    localparam int SW   = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int HALF = SQ_DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [SW-1:0] sec_cnt;
    logic [HW-1:0] sq_cnt;

    // One-second strobe on the last tick of each second.
    assign sec_pulse = tick && !init && (sec_cnt == SW'(TICKS_PER_SEC - 1));

    // Count ticks within the current second.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            sec_cnt <= '0;
        end else if (tick) begin
            if (sec_cnt == SW'(TICKS_PER_SEC - 1)) sec_cnt <= '0;
            else                                     sec_cnt <= sec_cnt + 1'b1;
        end
    end

    // Half-period counter and toggle for the square wave.
    always_ff @(posedge clk) begin
        if (!rst_n || !sq_en) begin
            sq_cnt <= '0;
            sq_out <= 1'b0;
        end else if (tick) begin
            if (sq_cnt == HW'(HALF - 1)) begin
                sq_cnt <= '0;
                sq_out <= ~sq_out;
            end else begin
                sq_cnt <= sq_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lms_mains_watch.sv
// Mains watcher: detects loss and return of zero crossings and long outages.
// Assumes: zc_in is synchronised; mains is taken as present at reset.
module lms_mains_watch #(
    parameter int ZC_LOSS_TICKS = 320,
    parameter int ZC_GAP_SEC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic zc_in,
    input  logic sec_pulse,
    output logic onoff_evt,
    output logic restart
);
    localparam int QW = (ZC_LOSS_TICKS > 1) ? $clog2(ZC_LOSS_TICKS) : 1;
    localparam int GW = $clog2(ZC_GAP_SEC + 1);

    logic          zc_q;
    logic          present;
    logic [QW-1:0] quiet;
    logic [GW-1:0] gap;

    // Edge detection, silence counting and the off/on event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_q      <= 1'b0;
            quiet     <= '0;
            present   <= 1'b1;
            onoff_evt <= 1'b0;
        end else begin
            zc_q      <= zc_in;
            onoff_evt <= 1'b0;
            if (zc_in != zc_q) begin
                quiet     <= '0;
                present   <= 1'b1;
                onoff_evt <= !present;
            end else if (tick && present) begin
                if (quiet == QW'(ZC_LOSS_TICKS - 1)) present <= 1'b0;
                else                                  quiet   <= quiet + 1'b1;
            end
        end
    end

    // Seconds of continuous absence; request restart once the limit is exceeded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= '0;
            restart <= 1'b0;
        end else begin
            restart <= 1'b0;
            if (present) begin
                gap <= '0;
            end else if (sec_pulse) begin
                if (gap == GW'(ZC_GAP_SEC)) begin
                    restart <= 1'b1;
                    gap     <= '0;
                end else begin
                    gap <= gap + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lms_gesture.sv
// Gesture detector: two off/on events inside a window of seconds give one pulse.
// Assumes: window length is at least two seconds; clr empties any half-made gesture.
module lms_gesture #(
    parameter int GESTURE_SEC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic evt,
    input  logic sec_pulse,
    output logic gesture
);
    localparam int WW = (GESTURE_SEC > 1) ? $clog2(GESTURE_SEC) : 1;

    logic          armed;
    logic [WW-1:0] win;

    // Arm on the first event, fire on the second, disarm when the window runs out.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed   <= 1'b0;
            win     <= '0;
            gesture <= 1'b0;
        end else begin
            gesture <= 1'b0;
            if (evt) begin
                if (armed) begin
                    gesture <= 1'b1;
                    armed   <= 1'b0;
                end else begin
                    armed <= 1'b1;
                    win   <= '0;
                end
            end else if (sec_pulse && armed) begin
                if (win == WW'(GESTURE_SEC - 1)) armed <= 1'b0;
                else                             win   <= win + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lms_state.sv
// Automatic-operation state machine with warm-up, quick-install and override timers.
// Assumes: auto_sel low forces the machine back to plain automatic operation.
module lms_state
    import lms_pkg::*;
#(
    parameter int WARMUP_SEC     = 40,
    parameter int QUICK_WIN_SEC  = 10,
    parameter int QUICK_IDLE_SEC = 32,
    parameter int OVR_ON_SEC     = 18000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     init,
    input  logic     auto_sel,
    input  logic     gesture,
    input  logic     trig,
    input  logic     sec_pulse,
    output auto_st_e st,
    output logic     warming
);
    localparam int UW   = $clog2(WARMUP_SEC + 1);
    localparam int TMAX = (OVR_ON_SEC > QUICK_IDLE_SEC) ? OVR_ON_SEC : QUICK_IDLE_SEC;
    localparam int TW   = $clog2(TMAX + 1);

    logic [UW-1:0] up;
    logic [TW-1:0] tmr;
    logic          in_qwin;

    assign warming = (up < UW'(WARMUP_SEC));
    assign in_qwin = (up < UW'(QUICK_WIN_SEC));

    // Seconds since initialization, saturating at the warm-up length.
    always_ff @(posedge clk) begin
        if (!rst_n || init)                          up <= '0;
        else if (sec_pulse && up != UW'(WARMUP_SEC)) up <= up + 1'b1;
    end

    // Mode transitions and the shared quick/override timer.
    always_ff @(posedge clk) begin
        if (!rst_n || init || !auto_sel) begin
            st  <= ST_AUTO;
            tmr <= '0;
        end else begin
            case (st)
                ST_AUTO: begin
                    if (gesture) begin
                        st  <= in_qwin ? ST_QUICK : ST_OVR_ON;
                        tmr <= '0;
                    end
                end
                ST_OVR_ON: begin
                    if (gesture) begin
                        st  <= ST_AUTO;
                        tmr <= '0;
                    end else if (sec_pulse) begin
                        if (tmr == TW'(OVR_ON_SEC - 1)) begin
                            st  <= ST_AUTO;
                            tmr <= '0;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                ST_QUICK: begin
                    if (trig) begin
                        tmr <= '0;
                    end else if (sec_pulse) begin
                        if (tmr == TW'(QUICK_IDLE_SEC - 1)) begin
                            st  <= ST_AUTO;
                            tmr <= '0;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                default: begin
                    st  <= ST_AUTO;
                    tmr <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lamp_mode_sequencer.sv
// Top: selector decoding, mains gesture handling and the registered effective mode.
// Assumes: mode_sel is already decoded and stable for many clocks between changes.
module lamp_mode_sequencer
    import lms_pkg::*;
#(
    parameter int TICKS_PER_SEC  = 16000,
    parameter int ZC_LOSS_TICKS  = 320,
    parameter int SQ_DIV         = 512,
    parameter int WARMUP_SEC     = 40,
    parameter int QUICK_WIN_SEC  = 10,
    parameter int GESTURE_SEC    = 3,
    parameter int QUICK_IDLE_SEC = 32,
    parameter int OVR_ON_SEC     = 18000,
    parameter int ZC_GAP_SEC     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] mode_sel,
    input  logic       zc_in,
    input  logic       trig,
    output logic [2:0] mode_o,
    output logic       warm_inh,
    output logic       sq_out
);
    logic      auto_sel;
    logic      sec_pulse;
    logic      onoff_evt;
    logic      restart;
    logic      gesture;
    logic      warming;
    auto_st_e  st;
    eff_mode_e eff_next;
    logic      inh_next;

    assign auto_sel = mode_sel[1];

    lms_prescale #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .SQ_DIV       (SQ_DIV)
    ) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .init     (restart),
        .sq_en    (auto_sel),
        .sec_pulse(sec_pulse),
        .sq_out   (sq_out)
    );

    lms_mains_watch #(
        .ZC_LOSS_TICKS(ZC_LOSS_TICKS),
        .ZC_GAP_SEC   (ZC_GAP_SEC)
    ) u_mains (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .zc_in    (zc_in),
        .sec_pulse(sec_pulse),
        .onoff_evt(onoff_evt),
        .restart  (restart)
    );

    lms_gesture #(
        .GESTURE_SEC(GESTURE_SEC)
    ) u_gesture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .evt      (onoff_evt),
        .sec_pulse(sec_pulse),
        .gesture  (gesture)
    );

    lms_state #(
        .WARMUP_SEC    (WARMUP_SEC),
        .QUICK_WIN_SEC (QUICK_WIN_SEC),
        .QUICK_IDLE_SEC(QUICK_IDLE_SEC),
        .OVR_ON_SEC    (OVR_ON_SEC)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (restart),
        .auto_sel (auto_sel),
        .gesture  (gesture),
        .trig     (trig),
        .sec_pulse(sec_pulse),
        .st       (st),
        .warming  (warming)
    );

    // Map selector and automatic state onto the reported mode and inhibit.
    always_comb begin
        if (!auto_sel) begin
            eff_next = mode_sel[0] ? EM_ON : EM_OFF;
        end else begin
            case (st)
                ST_QUICK:  eff_next = EM_QUICK;
                ST_OVR_ON: eff_next = EM_ON;
                default:   eff_next = warming ? EM_WARM : EM_AUTO;
            endcase
        end
        inh_next = warming && !(auto_sel && st == ST_QUICK);
    end

    // Register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o   <= EM_WARM;
            warm_inh <= 1'b1;
        end else begin
            mode_o   <= eff_next;
            warm_inh <= inh_next;
        end
    end

endmodule

// File: rtl/lms_checker.sv
// Cycle-level checks on the sequencer ports, attached by bind.
// Assumes: the effective-mode encoding from lms_pkg.
module lms_checker
    import lms_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] mode_sel,
    input logic [2:0] mode_o,
    input logic       warm_inh,
    input logic       sq_out
);
    // R1: forced-off selector yields OFF next cycle
    a_r1_low_gives_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> (mode_o == EM_OFF));

    // R1: forced-on selector yields ON next cycle
    a_r1_high_gives_on: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |=> (mode_o == EM_ON));

    // R2: square wave silent outside automatic selection
    a_r2_sq_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel[1]) |=> !sq_out);

    // R2: square wave changes only on a tick
    a_r2_sq_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[1] && !tick) |=> $stable(sq_out));

    // R3: only legal mode codes are reported
    a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o <= EM_WARM));

    // R3: warm-up mode always carries the inhibit
    a_r3_warm_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == EM_WARM) |-> warm_inh);

    // R6: quick-install never carries the inhibit
    a_r6_quick_no_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == EM_QUICK) |-> !warm_inh);

endmodule

bind lamp_mode_sequencer lms_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mode_sel(mode_sel),
    .mode_o  (mode_o),
    .warm_inh(warm_inh),
    .sq_out  (sq_out)
);

// File: tb/lamp_mode_sequencer_test.sv
// Scoreboard bench: tasks queue expected mode/inhibit pairs, a monitor pops and compares.
module lamp_mode_sequencer_test;
    localparam int CLK_PERIOD  = 10;
    localparam int TPS         = 8;
    localparam int CLK_PER_SEC = 2 * TPS;
    localparam int SQ_DIV      = 8;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick = 0;
    logic [1:0] mode_sel = 2'b10;
    logic       zc_in = 0;
    logic       trig = 0;
    logic [2:0] mode_o;
    logic       warm_inh;
    logic       sq_out;

    logic mains_on = 1;
    logic ph = 0;
    int   vectors = 0;
    int   fails = 0;
    int   cyc = 0;

    typedef struct {
        logic [2:0] m;
        logic       inh;
        string      tag;
    } exp_t;
    exp_t q[$];

    lamp_mode_sequencer #(
        .TICKS_PER_SEC (TPS),
        .ZC_LOSS_TICKS (3),
        .SQ_DIV        (SQ_DIV),
        .WARMUP_SEC    (40),
        .QUICK_WIN_SEC (10),
        .GESTURE_SEC   (3),
        .QUICK_IDLE_SEC(6),
        .OVR_ON_SEC    (20),
        .ZC_GAP_SEC    (3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
        .zc_in(zc_in), .trig(trig), .mode_o(mode_o), .warm_inh(warm_inh), .sq_out(sq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Tick every second clock; zero crossings toggle every second clock while mains is on.
    initial forever begin
        @(posedge clk); #1;
        tick = ~tick;
        ph   = ~ph;
        if (ph && mains_on) zc_in = ~zc_in;
    end

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            vectors++;
            if (mode_o !== e.m || warm_inh !== e.inh) begin
                fails++;
                $display("FAIL %s: mode=%0d inh=%0b expected mode=%0d inh=%0b",
                         e.tag, mode_o, warm_inh, e.m, e.inh);
            end
        end
    end

    task automatic expect_mode(input logic [2:0] m, input logic inh, input string tag);
        exp_t e;
        e.m = m; e.inh = inh; e.tag = tag;
        q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic secs(input int n);
        clks(n * CLK_PER_SEC);
    endtask

    task automatic onoff();
        mains_on = 0; secs(1);
        mains_on = 1; clks(CLK_PER_SEC / 2);
    endtask

    task automatic do_gesture();
        onoff();
        onoff();
        clks(CLK_PER_SEC / 2);
    endtask

    task automatic dip();
        mains_on = 0; clks(2);
        mains_on = 1;
    endtask

    task automatic pulse_trig();
        trig = 1; clks(1);
        trig = 0;
    endtask

    // Measure clocks between two changes of sq_out.
    task automatic check_sq_period();
        int t1, t2;
        @(sq_out); t1 = cyc;
        @(sq_out); t2 = cyc;
        vectors++;
        if (t2 - t1 != SQ_DIV) begin
            fails++;
            $display("FAIL R2: half period %0d clocks expected %0d", t2 - t1, SQ_DIV);
        end
        #1;
    endtask

    initial begin
        clks(4);
        rst_n = 1;
        #1;
        expect_mode(3'd4, 1'b1, "R3 reset state");
        secs(1);
        expect_mode(3'd4, 1'b1, "R3 warm-up running");
        check_sq_period();

        // R6 quick-install entry early after power-on
        secs(1);
        do_gesture();
        expect_mode(3'd3, 1'b0, "R6 quick entry");

        // R7 triggers keep quick mode alive
        repeat (4) begin
            secs(3);
            pulse_trig();
        end
        expect_mode(3'd3, 1'b0, "R7 retriggered quick");
        secs(8);
        expect_mode(3'd4, 1'b1, "R7 idle exit into unfinished warm-up");

        secs(17);
        expect_mode(3'd2, 1'b0, "R3 warm-up finished");

        // R4 short dips are not events
        dip(); secs(1); dip(); secs(1);
        expect_mode(3'd2, 1'b0, "R4 short dips ignored");

        // R5 two events far apart
        onoff(); secs(5); onoff(); secs(4);
        expect_mode(3'd2, 1'b0, "R5 events outside window");

        // R8 toggle
        do_gesture();
        expect_mode(3'd1, 1'b0, "R8 override on");
        do_gesture();
        expect_mode(3'd2, 1'b0, "R8 override back to auto");

        // R9 override expiry
        do_gesture();
        secs(10);
        expect_mode(3'd1, 1'b0, "R9 override still on");
        secs(12);
        expect_mode(3'd2, 1'b0, "R9 override expired");

        // R1 and R11 forced selections
        mode_sel = 2'b00; clks(2);
        expect_mode(3'd0, 1'b0, "R1 forced off");
        check_bit(sq_out, 1'b0, "R2 square idle when forced");
        do_gesture();
        expect_mode(3'd0, 1'b0, "R11 gesture ignored when forced off");
        mode_sel = 2'b01; clks(2);
        expect_mode(3'd1, 1'b0, "R1 forced on");
        mode_sel = 2'b10; clks(2);
        expect_mode(3'd2, 1'b0, "R11 no override taken while forced");
        mode_sel = 2'b11; clks(2);
        expect_mode(3'd2, 1'b0, "R1 code 11 is automatic");
        mode_sel = 2'b10;

        // R10 long outage restarts warm-up
        mains_on = 0; secs(5);
        mains_on = 1; secs(1);
        expect_mode(3'd4, 1'b1, "R10 restart warm-up");
        secs(3);
        do_gesture();
        expect_mode(3'd3, 1'b0, "R6 quick after restart");
        do_gesture();
        expect_mode(3'd3, 1'b0, "R11 gesture ignored in quick");

        clks(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule